// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This block holds two counters that advance together on a shared tick enable. The first is a 64-bit time base that counts up without stopping. The second is a 32-bit decrementer that counts down and requests a timer interrupt. Software reaches both through a small single-cycle register port. The port has a register select, a write strobe, write data, and read data that is driven combinationally. The 64-bit time base is reached as two 32-bit windows. Software can load either half alone and the other half is kept.

The interrupt request is raised whenever the decrementer's sign bit goes from clear to set. This happens either when a count from zero wraps to all-ones, or when software writes a negative value over a non-negative one. The request is a sticky level. It stays high until the interrupt acknowledge input clears it, and a new expiry always wins over an acknowledge given in the same cycle. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `tick_timer_unit`

## Requirements
- R1: While reset is held, and after it is released, the time base reads 0 in both halves, the decrementer reads 0xFFFFFFFF, and the interrupt request is low.
- R2: Each cycle with the tick enable high adds one to the 64-bit time base, and the carry passes from the lower half into the upper half. Select code 0 reads bits 31:0 and select code 1 reads bits 63:32, both combinationally.
- R3: A write with select 1 replaces bits 63:32 and keeps bits 31:0. A write with select 0 replaces bits 31:0 and keeps bits 63:32. In a cycle with such a write, the tick is not added to the time base.
- R4: Each tick reduces the decrementer by one. Select code 2 reads it.
- R5: A decrementer write whose bit 31 is set, while the current bit 31 is clear, raises the interrupt request in the next cycle. The same write over a decrementer whose bit 31 is already set raises nothing.
- R6: A tick while the decrementer holds zero loads 0xFFFFFFFF and raises the interrupt request in the next cycle.
- R7: Writing zero to the decrementer raises no interrupt in that cycle. The first tick afterwards expires it.
- R8: The interrupt request stays high until the acknowledge input is sampled high. It is low in the cycle after that acknowledge.
- R9: When an expiry and an acknowledge happen in the same cycle, the interrupt request stays high.
- R10: Select code 3 reads as zero, and a write with it changes no counter.
- R11: A decrementer write in a cycle with the tick high loads the written value, and the tick is not applied to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Advance both counters this cycle |
| reg_sel | input | 2 | 0 time base low, 1 time base high, 2 decrementer, 3 unused |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read of the selected register |
| irq_ack | input | 1 | Clears the interrupt request |
| irq_req | output | 1 | Sticky timer interrupt request |

## Verification
Writes and ticks land in the counters at the clock edge that samples them. Reads are combinational, so every counter result is due one edge after its stimulus. The interrupt request is registered once, so it also appears one edge after the write, the wrap or the acknowledge that causes it. The bench drives each vector on a falling edge and lets one rising edge pass. Shortly afterwards it drops the strobes, sets the select for the check, and compares the read data and the interrupt level in that same low phase. The reset check happens within a cycle of reset being asserted, because the asynchronous assertion clears every register without a clock edge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_TB_LO = 2'd0,
    SEL_TB_HI = 2'd1,
    SEL_DEC   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/tick_tb_counter.sv
module tick_tb_counter #(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned TB_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              tick_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  output logic [TB_W-1:0]   tb_q
);
  logic [TB_W-1:0] tb_d;
  logic            tb_ce;

  always_comb begin
    tb_ce = wr_lo | wr_hi | tick_en;
    tb_d  = tb_q;
    if (wr_lo)        tb_d = {tb_q[TB_W-1:HALF_W], wr_data};
    else if (wr_hi)   tb_d = {wr_data, tb_q[HALF_W-1:0]};
    else if (tick_en) tb_d = tb_q + {{(TB_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    tb_q <= '0;
    else if (tb_ce) tb_q <= tb_d;
  end
endmodule

// File: rtl/tick_dec_counter.sv
module tick_dec_counter #(
  parameter int unsigned DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             tick_en,
  input  logic             wr_dec,
  input  logic [DEC_W-1:0] wr_data,
  output logic [DEC_W-1:0] dec_q,
  output logic             expire
);
  logic [DEC_W-1:0] dec_d;
  logic             dec_ce;
  logic             wr_neg_edge;
  logic             cnt_wrap;

  always_comb begin
    wr_neg_edge = wr_dec & wr_data[DEC_W-1] & ~dec_q[DEC_W-1];
    cnt_wrap    = ~wr_dec & tick_en & (dec_q == '0);
    expire      = wr_neg_edge | cnt_wrap;
    dec_ce      = wr_dec | tick_en;
    dec_d       = dec_q;
    if (wr_dec)       dec_d = wr_data;
    else if (tick_en) dec_d = dec_q - {{(DEC_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     dec_q <= '1;
    else if (dec_ce) dec_q <= dec_d;
  end
endmodule

// File: rtl/tick_irq_latch.sv
module tick_irq_latch (
  input  logic clk,
  input  logic rst_ns,
  input  logic set_evt,
  input  logic ack,
  output logic irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = irq_q;
    if (set_evt)  irq_d = 1'b1;
    else if (ack) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tick_timer_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  localparam int unsigned TB_W = 2 * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic             irq_ack,
  output logic             irq_req
);
  logic            rst_ns;
  logic            wr_lo, wr_hi, wr_dec;
  logic [TB_W-1:0] tb_q;
  logic [DW-1:0]   dec_q;
  logic            expire;
  reg_sel_e        sel;

  assign sel = reg_sel_e'(reg_sel);

  tick_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  always_comb begin
    wr_lo  = wr_en & (sel == SEL_TB_LO);
    wr_hi  = wr_en & (sel == SEL_TB_HI);
    wr_dec = wr_en & (sel == SEL_DEC);
  end

  tick_tb_counter #(.HALF_W(DW)) u_tb (
    .clk(clk), .rst_ns(rst_ns), .tick_en(tick_en),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .tb_q(tb_q)
  );

  tick_dec_counter #(.DEC_W(DW)) u_dec (
    .clk(clk), .rst_ns(rst_ns), .tick_en(tick_en),
    .wr_dec(wr_dec), .wr_data(wr_data), .dec_q(dec_q), .expire(expire)
  );

  tick_irq_latch u_irq (
    .clk(clk), .rst_ns(rst_ns), .set_evt(expire), .ack(irq_ack), .irq_q(irq_req)
  );

  always_comb begin
    case (sel)
      SEL_TB_LO: rd_data = tb_q[DW-1:0];
      SEL_TB_HI: rd_data = tb_q[TB_W-1:DW];
      SEL_DEC:   rd_data = dec_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
  parameter int unsigned DW = 32,
  localparam int unsigned TB_W = 2 * DW
) (
  input logic            clk,
  input logic            rst_ns,
  input logic            tick_en,
  input logic [1:0]      reg_sel,
  input logic            wr_en,
  input logic [DW-1:0]   wr_data,
  input logic            irq_ack,
  input logic            irq_req,
  input logic [TB_W-1:0] tb_q,
  input logic [DW-1:0]   dec_q
);
  logic tb_write, dec_write;
  assign tb_write  = wr_en && (reg_sel == 2'd0 || reg_sel == 2'd1);
  assign dec_write = wr_en && reg_sel == 2'd2;

  assert_tb_count_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (tick_en && !tb_write) |=> tb_q == $past(tb_q) + 1'b1);

  assert_hi_keeps_lo_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && reg_sel == 2'd1) |=> (tb_q[DW-1:0] == $past(tb_q[DW-1:0]) && tb_q[TB_W-1:DW] == $past(wr_data)));

  assert_dec_count_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (tick_en && !dec_write) |=> dec_q == $past(dec_q) - 1'b1);

  assert_neg_write_irq_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (dec_write && wr_data[DW-1] && !dec_q[DW-1]) |=> irq_req);

  assert_wrap_irq_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (tick_en && !dec_write && dec_q == '0) |=> (irq_req && dec_q == '1));

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (irq_req && !irq_ack) |=> irq_req);

  assert_ack_wins_late_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (irq_ack && tick_en && !dec_write && dec_q == '0) |=> irq_req);

  assert_unused_sel_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && reg_sel == 2'd3 && !tick_en) |=> ($stable(tb_q) && $stable(dec_q)));

  assert_dec_write_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    dec_write |=> dec_q == $past(wr_data));
endmodule

bind tick_timer_unit tick_timer_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .tick_en(tick_en), .reg_sel(reg_sel),
  .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack), .irq_req(irq_req),
  .tb_q(tb_q), .dec_q(dec_q)
);

// File: tb/tick_timer_unit_bench.sv
module tick_timer_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic [1:0]  reg_sel;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq_ack;
  logic        irq_req;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  tick_timer_unit u_tick_timer_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic        tick;
    logic        wr;
    logic [1:0]  sel;
    logic [31:0] data;
    logic        ack;
    logic [1:0]  csel;
    logic [31:0] exp;
    logic        eirq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'd2,  1'b1, 1'b0, 2'd0, 32'h0,        1'b0, 2'd0, 32'h1,        1'b0},
    '{4'd2,  1'b1, 1'b0, 2'd0, 32'h0,        1'b0, 2'd0, 32'h2,        1'b0},
    '{4'd3,  1'b0, 1'b1, 2'd1, 32'h12345678, 1'b0, 2'd1, 32'h12345678, 1'b0},
    '{4'd3,  1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 2'd0, 32'h2,        1'b0},
    '{4'd3,  1'b1, 1'b1, 2'd0, 32'hFFFFFFFF, 1'b0, 2'd0, 32'hFFFFFFFF, 1'b0},
    '{4'd2,  1'b1, 1'b0, 2'd0, 32'h0,        1'b0, 2'd1, 32'h12345679, 1'b0},
    '{4'd2,  1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 2'd0, 32'h0,        1'b0},
    '{4'd11, 1'b1, 1'b1, 2'd2, 32'h5,        1'b0, 2'd2, 32'h5,        1'b0},
    '{4'd4,  1'b1, 1'b0, 2'd0, 32'h0,        1'b0, 2'd2, 32'h4,        1'b0},
    '{4'd5,  1'b0, 1'b1, 2'd2, 32'h80000000, 1'b0, 2'd2, 32'h80000000, 1'b1},
    '{4'd8,  1'b0, 1'b0, 2'd0, 32'h0,        1'b1, 2'd2, 32'h80000000, 1'b0},
    '{4'd5,  1'b0, 1'b1, 2'd2, 32'h90000000, 1'b0, 2'd2, 32'h90000000, 1'b0},
    '{4'd7,  1'b0, 1'b1, 2'd2, 32'h0,        1'b0, 2'd2, 32'h0,        1'b0},
    '{4'd6,  1'b1, 1'b0, 2'd0, 32'h0,        1'b0, 2'd2, 32'hFFFFFFFF, 1'b1},
    '{4'd8,  1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 2'd2, 32'hFFFFFFFF, 1'b1},
    '{4'd8,  1'b0, 1'b1, 2'd2, 32'h1,        1'b0, 2'd2, 32'h1,        1'b1},
    '{4'd4,  1'b1, 1'b0, 2'd0, 32'h0,        1'b0, 2'd2, 32'h0,        1'b1},
    '{4'd9,  1'b1, 1'b0, 2'd0, 32'h0,        1'b1, 2'd2, 32'hFFFFFFFF, 1'b1},
    '{4'd8,  1'b0, 1'b0, 2'd0, 32'h0,        1'b1, 2'd2, 32'hFFFFFFFF, 1'b0},
    '{4'd10, 1'b0, 1'b1, 2'd3, 32'hABCD,     1'b0, 2'd3, 32'h0,        1'b0},
    '{4'd10, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 2'd0, 32'h5,        1'b0},
    '{4'd10, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 2'd1, 32'h12345679, 1'b0}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] s, input string req, input logic [31:0] exp);
    reg_sel = s;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic apply(input logic t, input logic w, input logic [1:0] s,
                       input logic [31:0] d, input logic a);
    @(negedge clk);
    tick_en = t; wr_en = w; reg_sel = s; wr_data = d; irq_ack = a;
    @(posedge clk);
    #1;
    tick_en = 1'b0; wr_en = 1'b0; irq_ack = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; reg_sel = 2'd0;
    wr_data = '0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    peek(2'd2, "R1", 32'hFFFFFFFF);
    check("R1", {31'd0, irq_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: state after release
    peek(2'd0, "R1", 32'h0);
    peek(2'd1, "R1", 32'h0);
    peek(2'd2, "R1", 32'hFFFFFFFF);
    check("R1", {31'd0, irq_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      apply(VECS[i].tick, VECS[i].wr, VECS[i].sel, VECS[i].data, VECS[i].ack);
      reg_sel = VECS[i].csel;
      #1;
      check(tag, rd_data, VECS[i].exp);
      check(tag, {31'd0, irq_req}, {31'd0, VECS[i].eirq});
    end

    // R7: writing zero raises nothing until the next tick
    apply(1'b0, 1'b1, 2'd2, 32'h0, 1'b0);
    check("R7", {31'd0, irq_req}, 32'd0);
    apply(1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
    peek(2'd2, "R7", 32'h0);
    check("R7", {31'd0, irq_req}, 32'd0);
    // R5: negative write over zero raises the request
    apply(1'b0, 1'b1, 2'd2, 32'h80000000, 1'b0);
    check("R5", {31'd0, irq_req}, 32'd1);

    // R1: asynchronous reset clears the request and reloads the decrementer
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    peek(2'd2, "R1", 32'hFFFFFFFF);
    peek(2'd0, "R1", 32'h0);
    check("R1", {31'd0, irq_req}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule